// File: doc/BRIEF.md
# Four-State Bitwise Logic Unit

This unit applies one bitwise or reduction operation to vectors whose lanes each carry one of four logic values: 0, 1, z (high impedance) or x (unknown). Each operation follows dominance tables. A controlling value decides the result even when the other input is unknown. Otherwise x and z spread lane by lane. There is also a blend operation that keeps lanes on which both operands agree and marks every disagreement as x.

A caller presents a left vector, a right vector, an opcode, a destination lane index and a valid strobe. One clock later the result register holds the new left vector and a one-cycle completion pulse appears. For the two reduction operations, the unit folds every lane of the left vector into a single scalar. It returns that scalar on its own output and also writes it into the chosen lane of the left vector. The scalar is computed from the vector as it was before the write, so the destination lane is allowed to lie inside the source.

Top module: `quad_logic_unit`

## Requirements
- R1: Each lane is a 2-bit code: 00 = 0, 01 = 1, 10 = z, 11 = x; lane i sits at bits [2i+1:2i]. After reset, done is 0, every lane of res_vec is 00 and res_bit is 00.
- R2: Opcode 0 (AND): a 0 on either side gives 0, 1 with 1 gives 1, anything else gives x. Opcode 2 (NAND) gives the inverse: 1 where AND gives 0, 0 where AND gives 1, x otherwise.
- R3: Opcode 1 (OR): a 1 on either side gives 1, 0 with 0 gives 0, anything else gives x. Opcode 3 (NOR) gives the inverse of OR in the same way.
- R4: Opcode 4 (XOR) and opcode 5 (XNOR) give the two-valued result when both lanes are 0 or 1, and x if either lane is x or z.
- R5: Opcode 6 (invert) maps each left lane 0 to 1 and 1 to 0, and maps x and z to x. The right vector has no effect.
- R6: Opcode 7 (blend) gives the shared code when both lanes hold the same code (z with z gives z, x with x gives x) and gives x on any mismatch.
- R7: Opcode 8 (OR-reduce) sets res_bit to 1 if any left lane is 1, to 0 if all left lanes are 0, and to x otherwise. Opcode 9 (NOR-reduce) gives the inverse. res_vec becomes the left vector with lane dst_idx replaced by that scalar. The scalar is taken from the left vector before the replacement.
- R8: For opcode 8 or 9 with dst_idx not below the lane count, res_vec equals the left vector unchanged and res_bit still takes the scalar.
- R9: Opcodes 0 to 7 leave res_bit unchanged.
- R10: Opcodes 10 to 15 load the left vector unchanged into res_vec, leave res_bit unchanged and still pulse done.
- R11: Results and done appear on the first rising edge after in_valid is sampled high. done is high for exactly one cycle per accepted strobe. Without a strobe, res_vec and res_bit hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Accept the operands and opcode this cycle |
| op | input | 4 | Operation code |
| lhs | input | 2*N | Left vector, N lanes of 2-bit codes |
| rhs | input | 2*N | Right vector, N lanes of 2-bit codes |
| dst_idx | input | clog2(N) | Lane that receives a reduction result |
| res_vec | output | 2*N | Registered result vector |
| res_bit | output | 2 | Registered reduction scalar |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with N = 12. This width is not a power of two, so the 4-bit lane index can name lanes 12 to 15. Those out-of-range reduction destinations can then be driven and checked. Twelve lanes also let two operand vectors cover all sixteen code pairs for every two-input table. The same sixteen pairs exercise the controlling-value and mismatch cases without a wide sweep.

// File: rtl/quad_pkg.sv
package quad_pkg;

  typedef logic [1:0] qbit_t;

  localparam qbit_t Q_0 = 2'b00;
  localparam qbit_t Q_1 = 2'b01;
  localparam qbit_t Q_Z = 2'b10;
  localparam qbit_t Q_X = 2'b11;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_NAND  = 4'd2,
    OP_NOR   = 4'd3,
    OP_XOR   = 4'd4,
    OP_XNOR  = 4'd5,
    OP_INV   = 4'd6,
    OP_BLEND = 4'd7,
    OP_ORR   = 4'd8,
    OP_NORR  = 4'd9
  } qop_e;

  // a lane is two-valued when its upper code bit is clear
  function automatic logic q_known(qbit_t q);
    return ~q[1];
  endfunction

  function automatic qbit_t q_not(qbit_t q);
    return q_known(q) ? {1'b0, ~q[0]} : Q_X;
  endfunction

  function automatic qbit_t q_and(qbit_t a, qbit_t b);
    if (a == Q_0 || b == Q_0) return Q_0;
    if (a == Q_1 && b == Q_1) return Q_1;
    return Q_X;
  endfunction

  function automatic qbit_t q_or(qbit_t a, qbit_t b);
    if (a == Q_1 || b == Q_1) return Q_1;
    if (a == Q_0 && b == Q_0) return Q_0;
    return Q_X;
  endfunction

  function automatic qbit_t q_xor(qbit_t a, qbit_t b);
    if (q_known(a) && q_known(b)) return {1'b0, a[0] ^ b[0]};
    return Q_X;
  endfunction

  function automatic qbit_t q_blend(qbit_t a, qbit_t b);
    return (a == b) ? a : Q_X;
  endfunction

endpackage

// File: rtl/quad_bit_cell.sv
module quad_bit_cell
  import quad_pkg::*;
(
  input  logic [3:0] op,
  input  qbit_t      a,
  input  qbit_t      b,
  output qbit_t      y
);

  always_comb begin
    case (op)
      4'(OP_AND):   y = q_and(a, b);
      4'(OP_OR):    y = q_or(a, b);
      4'(OP_NAND):  y = q_not(q_and(a, b));
      4'(OP_NOR):   y = q_not(q_or(a, b));
      4'(OP_XOR):   y = q_xor(a, b);
      4'(OP_XNOR):  y = q_not(q_xor(a, b));
      4'(OP_INV):   y = q_not(a);
      4'(OP_BLEND): y = q_blend(a, b);
      default:      y = a;
    endcase
  end

endmodule

// File: rtl/quad_reduce.sv
module quad_reduce
  import quad_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [2*N-1:0] src,
  output qbit_t          any_or
);

  logic any_one;
  logic all_zero;

  always_comb begin
    any_one  = 1'b0;
    all_zero = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (src[2*i +: 2] == Q_1) any_one = 1'b1;
      if (src[2*i +: 2] != Q_0) all_zero = 1'b0;
    end
    if (any_one)       any_or = Q_1;
    else if (all_zero) any_or = Q_0;
    else               any_or = Q_X;
  end

  // the fold never reports high impedance
  always_comb begin
    assert_reduce_no_z_R7: assert (any_or != Q_Z);
  end

endmodule

// File: rtl/quad_logic_unit.sv
module quad_logic_unit
  import quad_pkg::*;
#(
  parameter int N = 16,
  localparam int W    = 2 * N,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  input  logic [IDXW-1:0] dst_idx,
  output logic [W-1:0]    res_vec,
  output logic [1:0]      res_bit,
  output logic            done
);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // lane datapath
  logic [W-1:0] cell_vec;

  for (genvar g = 0; g < N; g++) begin : g_lane
    quad_bit_cell u_cell (
      .op (op),
      .a  (lhs[2*g +: 2]),
      .b  (rhs[2*g +: 2]),
      .y  (cell_vec[2*g +: 2])
    );
  end

  qbit_t red_or;
  qbit_t red_val;
  logic  is_red;

  quad_reduce #(.N(N)) u_reduce (
    .src    (lhs),
    .any_or (red_or)
  );

  assign is_red  = (op == 4'(OP_ORR)) || (op == 4'(OP_NORR));
  assign red_val = (op == 4'(OP_NORR)) ? q_not(red_or) : red_or;

  // next state
  logic [W-1:0] vec_q, vec_nxt;
  qbit_t        bit_q, bit_nxt;
  logic         done_q, done_nxt;
  logic         load_en;

  assign load_en  = in_valid;
  assign done_nxt = in_valid;

  always_comb begin
    vec_nxt = vec_q;
    bit_nxt = bit_q;
    if (is_red) begin
      vec_nxt = lhs;
      for (int i = 0; i < N; i++) begin
        if (dst_idx == IDXW'(i)) vec_nxt[2*i +: 2] = red_val;
      end
      bit_nxt = red_val;
    end else begin
      vec_nxt = cell_vec;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vec_q  <= '0;
      bit_q  <= Q_0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
      if (load_en) begin
        vec_q <= vec_nxt;
        bit_q <= bit_nxt;
      end
    end
  end

  assign res_vec = vec_q;
  assign res_bit = bit_q;
  assign done    = done_q;

  // checking support
  logic lhs_known, rhs_known, res_known, res_has_z;

  always_comb begin
    lhs_known = 1'b1;
    rhs_known = 1'b1;
    res_known = 1'b1;
    res_has_z = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!q_known(lhs[2*i +: 2]))   lhs_known = 1'b0;
      if (!q_known(rhs[2*i +: 2]))   rhs_known = 1'b0;
      if (!q_known(vec_q[2*i +: 2])) res_known = 1'b0;
      if (vec_q[2*i +: 2] == Q_Z)    res_has_z = 1'b1;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> done);

  assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !done);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(res_vec) && $stable(res_bit)));

  assert_and_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == 4'(OP_AND) && lhs == '0) |=> (res_vec == '0));

  assert_xor_known_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == 4'(OP_XOR) && lhs_known && rhs_known) |=> res_known);

  assert_inv_no_z_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == 4'(OP_INV)) |=> !res_has_z);

  assert_bit_keep_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !op[3]) |=> $stable(res_bit));

endmodule

// File: tb/quad_logic_unit_tb_top.sv
module quad_logic_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 12;
  localparam int W    = 2 * N;
  localparam int IDXW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [3:0]      op;
  logic [W-1:0]    lhs, rhs;
  logic [IDXW-1:0] dst_idx;
  logic [W-1:0]    res_vec;
  logic [1:0]      res_bit;
  logic            done;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_logic_unit #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .lhs(lhs), .rhs(rhs), .dst_idx(dst_idx),
    .res_vec(res_vec), .res_bit(res_bit), .done(done)
  );

  // reference tables written from the requirements
  function automatic logic [1:0] m_not(logic [1:0] a);
    case (a)
      2'b00:   return 2'b01;
      2'b01:   return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] m_lane(int code, logic [1:0] a, logic [1:0] b);
    logic [1:0] t_and, t_or, t_xor;
    t_and = (a == 2'b00 || b == 2'b00) ? 2'b00 :
            (a == 2'b01 && b == 2'b01) ? 2'b01 : 2'b11;
    t_or  = (a == 2'b01 || b == 2'b01) ? 2'b01 :
            (a == 2'b00 && b == 2'b00) ? 2'b00 : 2'b11;
    t_xor = (a[1] || b[1]) ? 2'b11 : ((a == b) ? 2'b00 : 2'b01);
    case (code)
      0: return t_and;
      1: return t_or;
      2: return m_not(t_and);
      3: return m_not(t_or);
      4: return t_xor;
      5: return m_not(t_xor);
      6: return m_not(a);
      7: return (a == b) ? a : 2'b11;
      default: return a;
    endcase
  endfunction

  function automatic logic [W-1:0] m_vec(int code, logic [W-1:0] l, logic [W-1:0] r);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = m_lane(code, l[2*i +: 2], r[2*i +: 2]);
    return v;
  endfunction

  function automatic logic [1:0] m_red(int code, logic [W-1:0] l);
    logic [1:0] acc;
    acc = 2'b00;
    for (int i = 0; i < N; i++) acc = m_lane(1, acc, l[2*i +: 2]);
    return (code == 9) ? m_not(acc) : acc;
  endfunction

  // all sixteen code pairs, spread over lanes starting at base
  function automatic logic [W-1:0] pair_vec(int base, bit right);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (i + base) % 16;
      v[2*i +: 2] = right ? 2'(k) : 2'(k >> 2);
    end
    return v;
  endfunction

  function automatic logic [W-1:0] rnd_vec();
    return W'({$urandom(), $urandom()});
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one strobe, then sample after the capturing edge
  task automatic issue(int code, logic [W-1:0] l, logic [W-1:0] r, int d);
    @(negedge clk);
    op = 4'(code); lhs = l; rhs = r; dst_idx = IDXW'(d); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(string req, int code, logic [W-1:0] l, logic [W-1:0] r);
    issue(code, l, r, 0);
    chk(req, res_vec, m_vec(code, l, r));
    chk({req, " done"}, W'(done), W'(1));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; op = '0; lhs = '0; rhs = '0; dst_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset vec", res_vec, '0);
    chk("R1 reset bit", W'(res_bit), '0);
    chk("R1 reset done", W'(done), '0);
  endtask

  task automatic t_tables(string req, int code_a, int code_b);
    for (int b = 0; b < 2; b++) begin
      run_vec(req, code_a, pair_vec(b * N, 1'b0), pair_vec(b * N, 1'b1));
      run_vec(req, code_b, pair_vec(b * N, 1'b0), pair_vec(b * N, 1'b1));
    end
    for (int n = 0; n < 3; n++) begin
      run_vec(req, code_a, rnd_vec(), rnd_vec());
      run_vec(req, code_b, rnd_vec(), rnd_vec());
    end
  endtask

  task automatic t_invert();
    logic [W-1:0] l;
    l = pair_vec(0, 1'b1);
    run_vec("R5 invert", 6, l, '0);
    issue(6, l, '1, 0);
    chk("R5 rhs ignored", res_vec, m_vec(6, l, '0));
    run_vec("R5 invert rnd", 6, rnd_vec(), rnd_vec());
  endtask

  task automatic t_blend();
    run_vec("R6 blend pairs", 7, pair_vec(0, 1'b0), pair_vec(0, 1'b1));
    run_vec("R6 blend pairs", 7, pair_vec(N, 1'b0), pair_vec(N, 1'b1));
    run_vec("R6 blend equal", 7, {N{2'b10}}, {N{2'b10}});
  endtask

  task automatic red_case(string req, int code, logic [W-1:0] l, int d);
    logic [W-1:0] e;
    logic [1:0]   s;
    s = m_red(code, l);
    e = l;
    if (d < N) e[2*d +: 2] = s;
    issue(code, l, rnd_vec(), d);
    chk({req, " bit"}, W'(res_bit), W'(s));
    chk({req, " vec"}, res_vec, e);
  endtask

  task automatic t_reduce();
    logic [W-1:0] l;
    red_case("R7 orr zeros", 8, '0, 3);
    red_case("R7 norr zeros", 9, '0, 0);
    l = {N{2'b11}}; l[2*7 +: 2] = 2'b01;
    red_case("R7 orr one wins", 8, l, 2);
    l = '0; l[2*4 +: 2] = 2'b10;
    red_case("R7 orr z gives x", 8, l, 1);
    l = '0; l[2*5 +: 2] = 2'b01;
    red_case("R7 norr dst in src", 9, l, 5);
    red_case("R7 orr rnd", 8, rnd_vec(), 11);
  endtask

  task automatic t_reduce_oob();
    red_case("R8 dst 13", 8, pair_vec(3, 1'b1), 13);
    red_case("R8 dst 15", 9, '0, 15);
  endtask

  task automatic t_bit_hold();
    logic [W-1:0] l;
    l = '0; l[2*2 +: 2] = 2'b01;
    issue(8, l, '0, 0);
    for (int c = 0; c < 8; c++) begin
      issue(c, rnd_vec(), rnd_vec(), 0);
      chk("R9 res_bit held", W'(res_bit), W'(2'b01));
    end
  endtask

  task automatic t_undefined();
    logic [W-1:0] l;
    issue(9, '0, '0, 0);
    for (int c = 10; c < 16; c++) begin
      l = rnd_vec();
      issue(c, l, rnd_vec(), 0);
      chk("R10 vec pass", res_vec, l);
      chk("R10 bit held", W'(res_bit), W'(2'b01));
      chk("R10 done", W'(done), W'(1));
    end
  endtask

  task automatic t_timing();
    logic [W-1:0] a, b, held;
    a = rnd_vec(); b = rnd_vec();
    @(negedge clk);
    op = 4'd1; lhs = a; rhs = b; in_valid = 1'b1;
    @(negedge clk);
    chk("R11 first result", res_vec, m_vec(1, a, b));
    chk("R11 first done", W'(done), W'(1));
    op = 4'd4;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second result", res_vec, m_vec(4, a, b));
    chk("R11 second done", W'(done), W'(1));
    held = res_vec;
    lhs = rnd_vec(); op = 4'd0;
    @(negedge clk);
    chk("R11 done cleared", W'(done), W'(0));
    repeat (3) @(negedge clk);
    chk("R11 idle hold", res_vec, held);
  endtask

  initial begin
    t_reset();
    t_tables("R2 and/nand", 0, 2);
    t_tables("R3 or/nor", 1, 3);
    t_tables("R4 xor/xnor", 4, 5);
    t_invert();
    t_blend();
    t_reduce();
    t_reduce_oob();
    t_bit_hold();
    t_undefined();
    t_timing();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule